// File: doc/BRIEF.md
# Comparator output digital filter

This block takes the raw one-bit result of an analog comparator and conditions it in the digital clock domain. The raw bit can first pass through a two-flop synchronizer. It then goes through a glitch filter that is selected by a 3-bit mode and timed by a 12-bit length, counted in clock cycles. The last stage can invert the result.

The filter has four behaviours:
- **Immediate change with hold-off.** An edge is taken at the next clock, and the filter then ignores the input for a while.
- **Change after stable.** A new level is taken only after it has persisted.
- **Two asymmetric modes.** These debounce only one direction of change.

A separate bypass bit, a length of zero, or a non-filtering mode code lets the comparator result pass straight through. Hysteresis, input selection and the reference DAC belong to the analog side and are not part of this logic.

Top module: `cmp_deglitch`

## Requirements
- R1: The filter mode codes are 3'b100 immediate, 3'b101 after-stable, 3'b110 low-debounce and 3'b111 high-debounce. Codes 3'b000 to 3'b011 filter nothing: the output follows the (optionally synchronized) input in the same cycle.
- R2: When `flt_bypass_i` is 1, the filter is skipped whatever the mode. The output follows the (optionally synchronized) input in the same cycle.
- R3: When `sync_en_i` is 1, the raw bit reaches the filter two clock edges late. When it is 0, the raw bit reaches the filter with no register in between.
- R4: When `pol_inv_i` is 1, the output is inverted after the filter. When it is 0, the output is left as it is.
- R5: Immediate mode. A filter input that differs from the held output is taken at the next clock edge. For the next `flt_len_i` edges after that, the input is ignored.
- R6: After-stable mode. The held output changes at the edge where the filter input has differed from it on `flt_len_i` consecutive edges. If the input matches the output on any edge, the count restarts.
- R7: Low-debounce mode. A rise is taken at the next edge. A fall needs `flt_len_i` consecutive low edges, as in R6.
- R8: High-debounce mode. A fall is taken at the next edge. A rise needs `flt_len_i` consecutive high edges, as in R6.
- R9: With a filter length of 0, every filtering mode passes the input through in the same cycle.
- R10: A synchronous active-high reset clears the synchronizer flops, the held level and the counter. With `pol_inv_i` at 0, the output is 0 while the block is in a filtering mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_raw_i | input | 1 | Raw comparator result |
| sync_en_i | input | 1 | Insert the two-flop synchronizer |
| flt_bypass_i | input | 1 | Skip the filter |
| flt_mode_i | input | 3 | Filter mode code |
| flt_len_i | input | 12 | Filter length in clock cycles |
| pol_inv_i | input | 1 | Invert the final output |
| cmp_out_o | output | 1 | Conditioned comparator result |

## Verification
The hardest situations to reach are the counter boundaries. One is an input that flips back exactly one edge before the after-stable count completes. The other is an edge that arrives in the last cycle of an immediate-mode hold-off. The stimulus holds each input level for a random run of 1 to length+3 cycles, which places such flips on both sides of every boundary. It sweeps every mode code against short lengths (0, 1, 2, 3, 5) and every combination of sync, bypass and polarity, and compares against a cycle model written from the requirements.

// File: rtl/cmpflt_pkg.sv
package cmpflt_pkg;
  localparam int unsigned LEN_W_DEF = 12;

  typedef enum logic [2:0] {
    FM_PASS  = 3'b000,
    FM_IMM   = 3'b100,
    FM_AFTER = 3'b101,
    FM_SLO   = 3'b110,
    FM_SHI   = 3'b111
  } flt_mode_e;

  // a mode filters only when its top bit is set
  function automatic logic is_filtering(input logic [2:0] m);
    return m[2];
  endfunction

  // true when one more differing edge completes a run of length len
  function automatic logic run_complete(input logic [LEN_W_DEF-1:0] cnt,
                                        input logic [LEN_W_DEF-1:0] len);
    return ({1'b0, cnt} + 13'd1) >= {1'b0, len};
  endfunction
endpackage

// File: rtl/cmpflt_sync.sv
module cmpflt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic en_i,
  output logic s_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= raw_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], raw_i};
      end
    end
  endgenerate

  assign s_o = en_i ? chain_q[STAGES-1] : raw_i;
endmodule

// File: rtl/cmpflt_core.sv
module cmpflt_core
  import cmpflt_pkg::*;
#(
  parameter int unsigned LEN_W = LEN_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_i,
  input  logic [2:0]       mode_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             out_o
);
  logic             filt_q;
  logic [LEN_W-1:0] cnt_q;

  // named events used by the update logic and the assertions
  logic flt_active, diff, hold_busy, run_done, pass_now;
  logic is_imm, is_after, is_slo, is_shi;

  assign is_imm     = (mode_i == FM_IMM);
  assign is_after   = (mode_i == FM_AFTER);
  assign is_slo     = (mode_i == FM_SLO);
  assign is_shi     = (mode_i == FM_SHI);
  assign flt_active = is_filtering(mode_i) && (len_i != '0);
  assign diff       = (s_i != filt_q);
  assign hold_busy  = (cnt_q != '0);
  assign run_done   = run_complete(cnt_q, len_i);
  assign pass_now   = diff && ((is_slo && s_i) || (is_shi && !s_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!flt_active) begin
      filt_q <= s_i;
      cnt_q  <= '0;
    end else if (is_imm) begin
      if (hold_busy) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (diff) begin
        filt_q <= s_i;
        cnt_q  <= len_i;
      end
    end else if (pass_now) begin
      filt_q <= s_i;
      cnt_q  <= '0;
    end else if (!diff) begin
      cnt_q <= '0;
    end else if (run_done) begin
      filt_q <= s_i;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign out_o = flt_active ? filt_q : s_i;

  p_holdoff_r5: assert property (@(posedge clk) disable iff (rst)
    (flt_active && is_imm && hold_busy) |=> $stable(filt_q))
    else $error("R5 hold-off violated");

  p_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (flt_active && is_after && diff && !run_done) |=> $stable(filt_q))
    else $error("R6 early change");

  p_rise_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (flt_active && is_slo && s_i && !filt_q) |=> filt_q)
    else $error("R7 rise not passed");

  p_fall_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (flt_active && is_shi && !s_i && filt_q) |=> !filt_q)
    else $error("R8 fall not passed");
endmodule

// File: rtl/cmp_deglitch.sv
module cmp_deglitch
  import cmpflt_pkg::*;
#(
  parameter int unsigned LEN_W       = LEN_W_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_raw_i,
  input  logic             sync_en_i,
  input  logic             flt_bypass_i,
  input  logic [2:0]       flt_mode_i,
  input  logic [LEN_W-1:0] flt_len_i,
  input  logic             pol_inv_i,
  output logic             cmp_out_o
);
  logic       s_sync;
  logic       filt_out;
  logic [2:0] eff_mode;

  // bypass forces a non-filtering code, R2
  assign eff_mode = flt_bypass_i ? 3'(FM_PASS) : flt_mode_i;

  cmpflt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_i(cmp_raw_i), .en_i(sync_en_i), .s_o(s_sync)
  );

  cmpflt_core #(.LEN_W(LEN_W)) u_core (
    .clk(clk), .rst(rst), .s_i(s_sync), .mode_i(eff_mode),
    .len_i(flt_len_i), .out_o(filt_out)
  );

  assign cmp_out_o = filt_out ^ pol_inv_i;

  p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
    (flt_bypass_i && !sync_en_i) |-> (cmp_out_o == (cmp_raw_i ^ pol_inv_i)))
    else $error("R2 bypass not transparent");
endmodule

// File: tb/sim_cmp_deglitch.sv
`timescale 1ns/1ps
module sim_cmp_deglitch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        raw = 1'b0, sync_en = 1'b0, byp = 1'b0, pol = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [11:0] len = 12'd0;
  logic        out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmp_deglitch u0 (
    .clk(clk), .rst(rst), .cmp_raw_i(raw), .sync_en_i(sync_en),
    .flt_bypass_i(byp), .flt_mode_i(mode), .flt_len_i(len),
    .pol_inv_i(pol), .cmp_out_o(out)
  );

  // reference model written from the requirements
  logic m_sh1 = 0, m_sh2 = 0, m_out = 0;
  int   m_run = 0, m_hold = 0;
  logic ms;
  assign ms = sync_en ? m_sh2 : raw;

  function automatic logic model_active();
    logic [2:0] em;
    em = byp ? 3'b000 : mode;
    return em[2] && (len != 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sh1 <= 0; m_sh2 <= 0; m_out <= 0; m_run <= 0; m_hold <= 0;
    end else begin
      m_sh1 <= raw; m_sh2 <= m_sh1;
      if (!model_active()) begin
        m_out <= ms; m_run <= 0; m_hold <= 0;
      end else if (mode == 3'b100) begin
        m_run <= 0;
        if (m_hold > 0) m_hold <= m_hold - 1;
        else if (ms != m_out) begin m_out <= ms; m_hold <= int'(len); end
      end else begin
        m_hold <= 0;
        if (ms == m_out) m_run <= 0;
        else if ((mode == 3'b110 && ms) || (mode == 3'b111 && !ms)) begin
          m_out <= ms; m_run <= 0;
        end else if (m_run + 1 >= int'(len)) begin
          m_out <= ms; m_run <= 0;
        end else m_run <= m_run + 1;
      end
    end
  end

  function automatic logic expected();
    return (model_active() ? m_out : ms) ^ pol;
  endfunction

  function automatic string tag();
    string t;
    if (byp) t = "R2";
    else if (mode[2] && len == 0) t = "R9";
    else case (mode)
      3'b100: t = "R5";
      3'b101: t = "R6";
      3'b110: t = "R7";
      3'b111: t = "R8";
      default: t = "R1";
    endcase
    if (sync_en) t = {t, " R3"};
    if (pol) t = {t, " R4"};
    return t;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: out=%0b expected=%0b mode=%03b len=%0d", req, act, exp, mode, len);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: out=%0b expected=done", out);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens[5] = '{0, 1, 2, 3, 5};
    // R10: reset state in a filtering mode with a high raw input
    mode = 3'b101; len = 12'd4; raw = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R10", out, 1'b0);
    do_reset();
    check("R10", out, 1'b0);

    // R3: two-edge latency through the synchronizer
    mode = 3'b000; sync_en = 1'b1; raw = 1'b0;
    do_reset();
    raw = 1'b1;
    @(negedge clk); check("R3", out, 1'b0);
    @(negedge clk); check("R3", out, 1'b1);

    // R4: inversion in pass-through
    sync_en = 1'b0; pol = 1'b1; raw = 1'b0;
    @(negedge clk); check("R4", out, 1'b1);

    // sweep all configurations
    for (int m = 0; m < 8; m++)
      for (int li = 0; li < 5; li++)
        for (int c = 0; c < 8; c++) begin
          mode = 3'(m); len = 12'(lens[li]);
          sync_en = c[0]; byp = c[1]; pol = c[2];
          raw = 1'b0;
          do_reset();
          begin
            int run = 1;
            for (int k = 0; k < 60; k++) begin
              check(tag(), out, expected());
              run--;
              if (run <= 0) begin
                raw = ~raw;
                run = $urandom_range(1, lens[li] + 3);
              end
              @(negedge clk);
            end
          end
        end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule